// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block puts one raw NAND flash command on an 8-bit or 16-bit NAND bus. A request carries an operation type (device reset, page read, spare-area read, or random data out), a block number, a page number within the block and a column offset. The block turns this request into a series of bus cycles. Each cycle is either a command latch with CLE high or an address latch with ALE high. It drives the chip enable, the write strobe and the output data byte, and it watches the ready/busy line.

A spare-area read goes out as an ordinary page read, with the page data size added to the column. A page read ends with the read-confirm opcode and then waits until the device is ready again. A random data out ends with its own confirm opcode and does not wait. A reset latches only its opcode, releases chip enable and waits for ready. The block does not read data bytes, compute ECC, or issue program or erase commands.

Opcode values: read 0x00, read confirm 0x30, random out 0x05, random-out confirm 0xE0, reset 0xFF.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the outputs are idle:
  - `nand_ce_n`=1, `nand_we_n`=1, `nand_cle`=0, `nand_ale`=0 and `done`=0.
  - `req_ready` is high only while idle.
  - A `req_valid` pulse while `req_ready` is low adds no bus cycle and changes nothing.
- R2: After a request is accepted, no write strobe begins until the synchronized `nand_rb` reads ready (1).
- R3: A page read (`req_op`=1) emits these cycles in order, then waits for `nand_rb` to read ready before `done`:
  - CLE 0x00
  - ALE column[7:0]
  - ALE column[15:8]
  - ALE row[7:0]
  - ALE row[15:8]
  - CLE 0x30
- R4: The row address is page + block × PAGES_PER_BLOCK (64 by default), sent low byte first.
- R5: A spare-area read (`req_op`=2) uses the same opcodes and order as a page read, with 2048 added to the column offset.
- R6: When `bus16` is 1, the column is shifted right by one bit before it is sent. For a spare-area read the shift is applied after the 2048 is added.
- R7: When `five_cycle` is 1, an extra ALE cycle carrying {4'h0, row[19:16]} follows the row middle byte and comes before the confirm opcode.
- R8: Random data out (`req_op`=3) emits CLE 0x05, the same address cycles, then CLE 0xE0. It pulses `done` without waiting on `nand_rb`.
- R9: Reset (`req_op`=0) emits a single CLE 0xFF cycle and no address cycle. It then holds `nand_ce_n` high and waits for ready before `done`.
- R10: Each bus cycle holds `nand_we_n` low for `we_low_clks` clocks, with 0 treated as 1.
  - CLE, ALE and the data byte stay stable while `nand_we_n` is low.
  - CLE and ALE are never high together.
- R11: `done` is a single-cycle pulse.
- R12: `nand_ce_n` is low during every write strobe and high during the busy wait after the last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_op | input | 2 | 0 reset, 1 page read, 2 spare read, 3 random out |
| req_block | input | BLOCK_W (12) | Block number |
| req_page | input | PAGE_W (6) | Page within block |
| req_col | input | COL_W (12) | Column byte offset |
| bus16 | input | 1 | 16-bit bus: column sent as word address |
| five_cycle | input | 1 | Add the third row address cycle |
| we_low_clks | input | STROBE_W (4) | Write strobe low time in clocks |
| req_ready | output | 1 | Idle, a request may be given |
| nand_rb | input | 1 | Ready/busy from the device, 1 = ready, asynchronous |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_dq_out | output | 8 | Byte driven during a cycle |
| done | output | 1 | Sequence finished pulse |

## Verification
The bench applies several request patterns, and each one separates different behaviour:
- Page reads at small and at extreme block and page values show whether the row is formed from block × 64 + page, and whether its bytes go out in the right order.
- Spare reads with and without `bus16` show whether the 2048 is added before the halving or after it.
- Five-cycle runs show whether the extra row nibble is present and where it sits.
- A random-out request is completed while the bench holds the device busy, so a design that waits on busy is caught.
- A request given while the device is busy shows whether the pre-latch wait is honoured.
- A request pulsed mid-sequence shows whether extra input is ignored.
- Strobe lengths of 0, 1, 2 and 5 exercise the timing rule.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_RESET  = 2'd0,
        OP_READ   = 2'd1,
        OP_SPARE  = 2'd2,
        OP_RNDOUT = 2'd3
    } nand_op_e;

    typedef struct packed {
        logic       is_cmd;
        logic [7:0] val;
    } bus_cyc_t;

    localparam int MAX_CYC = 7;

    localparam logic [7:0] OPC_READ    = 8'h00;
    localparam logic [7:0] OPC_READ_GO = 8'h30;
    localparam logic [7:0] OPC_RND     = 8'h05;
    localparam logic [7:0] OPC_RND_GO  = 8'hE0;
    localparam logic [7:0] OPC_RST     = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT_PRE, ST_SETUP, ST_STROBE, ST_HOLD, ST_WAIT_POST, ST_DONE
    } seq_st_e;

    function automatic bus_cyc_t cmd_cyc(input logic [7:0] v);
        bus_cyc_t c;
        c.is_cmd = 1'b1;
        c.val    = v;
        return c;
    endfunction

    function automatic bus_cyc_t adr_cyc(input logic [7:0] v);
        bus_cyc_t c;
        c.is_cmd = 1'b0;
        c.val    = v;
        return c;
    endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rb_in,
    output logic rb_out
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], rb_in};
    end

    assign rb_out = sh[STAGES-1];
endmodule

// File: rtl/nand_seq_build.sv
module nand_seq_build
    import nand_seq_pkg::*;
#(
    parameter int BLOCK_W    = 12,
    parameter int PAGE_W     = 6,
    parameter int COL_W      = 12,
    parameter int PPB        = 64,
    parameter int PAGE_BYTES = 2048
) (
    input  nand_op_e                 op,
    input  logic [BLOCK_W-1:0]       blk,
    input  logic [PAGE_W-1:0]        page,
    input  logic [COL_W-1:0]         col,
    input  logic                     wide,
    input  logic                     five,
    output bus_cyc_t [MAX_CYC-1:0]   seq,
    output logic [2:0]               n_cyc,
    output logic                     wait_rdy
);
    localparam int ROW_W = 20;
    localparam int CA_W  = 16;

    logic [CA_W-1:0]  colw;
    logic [ROW_W-1:0] row;
    logic [7:0]       go_opc;

    always_comb begin
        colw = CA_W'(col);
        if (op == OP_SPARE) colw = colw + CA_W'(PAGE_BYTES);
        if (wide)           colw = colw >> 1;
        row    = ROW_W'(blk) * ROW_W'(PPB) + ROW_W'(page);
        go_opc = (op == OP_RNDOUT) ? OPC_RND_GO : OPC_READ_GO;
    end

    always_comb begin
        seq      = '0;
        n_cyc    = 3'd1;
        wait_rdy = 1'b1;
        if (op == OP_RESET) begin
            seq[0] = cmd_cyc(OPC_RST);
        end else begin
            seq[0]   = cmd_cyc((op == OP_RNDOUT) ? OPC_RND : OPC_READ);
            seq[1]   = adr_cyc(colw[7:0]);
            seq[2]   = adr_cyc(colw[15:8]);
            seq[3]   = adr_cyc(row[7:0]);
            seq[4]   = adr_cyc(row[15:8]);
            wait_rdy = (op != OP_RNDOUT);
            if (five) begin
                seq[5] = adr_cyc({4'h0, row[19:16]});
                seq[6] = cmd_cyc(go_opc);
                n_cyc  = 3'd7;
            end else begin
                seq[5] = cmd_cyc(go_opc);
                n_cyc  = 3'd6;
            end
        end
    end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int BLOCK_W    = 12,
    parameter int PAGE_W     = 6,
    parameter int COL_W      = 12,
    parameter int PPB        = 64,
    parameter int PAGE_BYTES = 2048,
    parameter int STROBE_W   = 4,
    parameter int GUARD_CLKS = 4,
    parameter int SYNC_STG   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [BLOCK_W-1:0]  req_block,
    input  logic [PAGE_W-1:0]   req_page,
    input  logic [COL_W-1:0]    req_col,
    input  logic                bus16,
    input  logic                five_cycle,
    input  logic [STROBE_W-1:0] we_low_clks,
    output logic                req_ready,
    input  logic                nand_rb,
    output logic                nand_cle,
    output logic                nand_ale,
    output logic                nand_ce_n,
    output logic                nand_we_n,
    output logic [7:0]          nand_dq_out,
    output logic                done
);
    localparam int GW    = $clog2(GUARD_CLKS + 1);
    localparam int CNT_W = (STROBE_W > GW) ? STROBE_W : GW;

    logic                    rb_s;
    bus_cyc_t [MAX_CYC-1:0]  seq_n, seq_q;
    logic [2:0]              ncyc_n, ncyc_q, idx;
    logic                    wait_n, wait_q;
    logic [STROBE_W-1:0]     len_q;
    logic [CNT_W-1:0]        cnt;
    seq_st_e                 st;
    bus_cyc_t                cur;
    logic                    active;

    nand_rb_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst), .rb_in(nand_rb), .rb_out(rb_s)
    );

    nand_seq_build #(
        .BLOCK_W(BLOCK_W), .PAGE_W(PAGE_W), .COL_W(COL_W),
        .PPB(PPB), .PAGE_BYTES(PAGE_BYTES)
    ) u_build (
        .op(nand_op_e'(req_op)), .blk(req_block), .page(req_page),
        .col(req_col), .wide(bus16), .five(five_cycle),
        .seq(seq_n), .n_cyc(ncyc_n), .wait_rdy(wait_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            seq_q  <= '0;
            ncyc_q <= 3'd1;
            wait_q <= 1'b0;
            len_q  <= STROBE_W'(1);
            idx    <= '0;
            cnt    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    seq_q  <= seq_n;
                    ncyc_q <= ncyc_n;
                    wait_q <= wait_n;
                    len_q  <= (we_low_clks == '0) ? STROBE_W'(1) : we_low_clks;
                    idx    <= '0;
                    st     <= ST_WAIT_PRE;
                end
                ST_WAIT_PRE: if (rb_s) st <= ST_SETUP;
                ST_SETUP: begin
                    cnt <= CNT_W'(len_q - STROBE_W'(1));
                    st  <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (cnt == '0) st <= ST_HOLD;
                    else           cnt <= cnt - CNT_W'(1);
                end
                ST_HOLD: begin
                    if (idx == ncyc_q - 3'd1) begin
                        if (wait_q) begin
                            cnt <= CNT_W'(GUARD_CLKS);
                            st  <= ST_WAIT_POST;
                        end else begin
                            st <= ST_DONE;
                        end
                    end else begin
                        idx <= idx + 3'd1;
                        st  <= ST_SETUP;
                    end
                end
                ST_WAIT_POST: begin
                    if (cnt != '0)  cnt <= cnt - CNT_W'(1);
                    else if (rb_s)  st  <= ST_DONE;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cur         = seq_q[idx];
        active      = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
        nand_ce_n   = !active;
        nand_cle    = active && cur.is_cmd;
        nand_ale    = active && !cur.is_cmd;
        nand_we_n   = (st != ST_STROBE);
        nand_dq_out = active ? cur.val : 8'h00;
        done        = (st == ST_DONE);
        req_ready   = (st == ST_IDLE);
    end
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cle,
    input logic       ale,
    input logic       ce_n,
    input logic       we_n,
    input logic [7:0] dq,
    input logic       done,
    input logic       ready
);
    p_no_dual_latch_r10: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    p_stable_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> ($stable(cle) && $stable(ale) && $stable(dq)));

    p_ce_on_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ce_n);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ready |-> (we_n && ce_n && !cle && !ale && !done));
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
    .clk(clk), .rst(rst), .cle(nand_cle), .ale(nand_ale), .ce_n(nand_ce_n),
    .we_n(nand_we_n), .dq(nand_dq_out), .done(done), .ready(req_ready)
);

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
    localparam int CLK_PER = 10;

    logic        clk = 0, rst = 1;
    logic        req_valid = 0;
    logic [1:0]  req_op = 0;
    logic [11:0] req_block = 0;
    logic [5:0]  req_page = 0;
    logic [11:0] req_col = 0;
    logic        bus16 = 0, five_cycle = 0;
    logic [3:0]  we_low_clks = 1;
    logic        req_ready, nand_rb, nand_cle, nand_ale, nand_ce_n, nand_we_n, done;
    logic [7:0]  nand_dq_out;

    int checks = 0, fails = 0;
    logic [9:0] exp_q[$];
    int  exp_width = 1;
    int  cap_count = 0;
    int  busy_timer = 0;
    logic hold_busy = 0;

    assign nand_rb = !(hold_busy || busy_timer != 0);

    always #(CLK_PER/2) clk = ~clk;

    nand_cmd_seq u_nand_cmd_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_block(req_block), .req_page(req_page), .req_col(req_col),
        .bus16(bus16), .five_cycle(five_cycle), .we_low_clks(we_low_clks),
        .req_ready(req_ready), .nand_rb(nand_rb), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
        .nand_dq_out(nand_dq_out), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected bus cycle when each write strobe ends
    logic       prev_we = 1;
    int         low_cnt = 0;
    logic [9:0] low_val;
    logic       low_ce;
    always @(negedge clk) begin
        if (busy_timer != 0) begin
            if (busy_timer == 10) chk(nand_ce_n == 1'b1, "R12 ce high in wait", nand_ce_n, 1);
            busy_timer--;
        end
        if (!rst) begin
            if (!nand_we_n) begin
                if (prev_we) begin
                    low_val = {nand_cle, nand_ale, nand_dq_out};
                    low_ce  = nand_ce_n;
                    low_cnt = 1;
                end else begin
                    if ({nand_cle, nand_ale, nand_dq_out} != low_val)
                        chk(0, "R10 stable during strobe", {nand_cle, nand_ale, nand_dq_out}, low_val);
                    low_cnt++;
                end
            end else if (!prev_we) begin
                cap_count++;
                chk(low_ce == 1'b0, "R12 ce low on strobe", low_ce, 0);
                chk(low_cnt == exp_width, "R10 strobe width", low_cnt, exp_width);
                if (exp_q.size() == 0) begin
                    chk(0, "R1 unexpected bus cycle", low_val, 0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk(low_val == e, "R3-R9 bus cycle {cle,ale,dq}", low_val, e);
                end
                if (low_val[9] && (low_val[7:0] == 8'h30 || low_val[7:0] == 8'hFF))
                    busy_timer = 15;
                if (low_val[9] && low_val[7:0] == 8'hE0)
                    busy_timer = 50;  // R8: device held busy, must not be waited on
            end
            prev_we = nand_we_n;
        end
    end

    task automatic do_req(input logic [1:0] op, input int blk, input int pg, input int col,
                          input bit wide, input bit five, input int wl,
                          input int hold, input bit poke, input string tag);
        int c, r, n;
        bit got;
        exp_width = (wl == 0) ? 1 : wl;
        if (op == 2'd0) begin
            exp_q.push_back({2'b10, 8'hFF});
        end else begin
            c = col;
            if (op == 2'd2) c = c + 2048;
            if (wide) c = c / 2;
            r = blk * 64 + pg;
            exp_q.push_back({2'b10, (op == 2'd3) ? 8'h05 : 8'h00});
            exp_q.push_back({2'b01, 8'(c)});
            exp_q.push_back({2'b01, 8'(c >> 8)});
            exp_q.push_back({2'b01, 8'(r)});
            exp_q.push_back({2'b01, 8'(r >> 8)});
            if (five) exp_q.push_back({2'b01, 4'h0, 4'(r >> 16)});
            exp_q.push_back({2'b10, (op == 2'd3) ? 8'hE0 : 8'h30});
        end
        @(negedge clk);
        req_op = op; req_block = 12'(blk); req_page = 6'(pg); req_col = 12'(col);
        bus16 = wide; five_cycle = five; we_low_clks = 4'(wl);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        n = cap_count;
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk(cap_count == n && nand_we_n == 1'b1, {"R2 no strobe while busy ", tag}, cap_count, n);
            hold_busy = 0;
        end
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(req_ready == 1'b0, {"R1 ready low when busy ", tag}, req_ready, 0);
            req_op = 2'd0; req_block = 12'h5A5; req_col = 12'h123; req_valid = 1;
            @(negedge clk);
            req_valid = 0;
        end
        got = 0;
        for (int i = 0; i < 3000 && !got; i++) begin
            if (done) got = 1;
            else @(negedge clk);
        end
        chk(got, {"R3 done seen ", tag}, got, 1);
        if (op == 2'd3) chk(nand_rb == 1'b0, {"R8 done without wait ", tag}, nand_rb, 0);
        else            chk(nand_rb == 1'b1, {"R3/R9 done after ready ", tag}, nand_rb, 1);
        @(negedge clk);
        chk(done == 1'b0, {"R11 done one cycle ", tag}, done, 0);
        chk(exp_q.size() == 0, {"R3 all cycles seen ", tag}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(nand_ce_n == 1 && nand_we_n == 1 && nand_cle == 0 && nand_ale == 0 && done == 0,
            "R1 reset outputs", {nand_ce_n, nand_we_n, nand_cle, nand_ale, done}, 5'b11000);
        chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
        do_req(2'd1, 3, 5, 12'h010, 0, 0, 2, 0, 0, "R3 R4 read");
        do_req(2'd1, 4095, 63, 12'h7FF, 0, 1, 1, 0, 0, "R7 R4 five-cycle max row");
        do_req(2'd1, 17, 2, 12'h3C4, 0, 1, 3, 0, 0, "R7 five-cycle small row");
        do_req(2'd2, 2, 1, 5, 0, 0, 1, 0, 0, "R5 spare 8-bit");
        do_req(2'd2, 9, 40, 6, 1, 0, 2, 0, 0, "R6 R5 spare 16-bit");
        do_req(2'd1, 1, 0, 12'h101, 1, 0, 1, 0, 0, "R6 read 16-bit");
        do_req(2'd3, 7, 7, 12'h200, 0, 0, 1, 0, 0, "R8 random out");
        do_req(2'd0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 reset op");
        do_req(2'd1, 100, 10, 12'h0AB, 0, 0, 0, 0, 0, "R10 zero strobe");
        do_req(2'd3, 55, 33, 12'hFFF, 1, 1, 5, 0, 0, "R10 R8 long strobe");
        hold_busy = 1;
        do_req(2'd1, 8, 8, 12'h020, 0, 0, 1, 12, 0, "R2 pre-wait");
        do_req(2'd1, 12, 3, 12'h044, 0, 0, 2, 0, 1, "R1 ignore mid-sequence");
        chk(req_ready == 1, "R1 idle at end", req_ready, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule